// File: doc/BRIEF.md
# Amplifier Gain Configuration Sequencer

This block programs a dual-channel programmable-gain amplifier exactly once after reset, over a three-wire synchronous serial link: a serial clock, a data line from the block and an active-low select. It builds an 8-bit gain word from one 3-bit code per channel. It pulls the select low and sends the word most significant bit first, one bit per serial-clock period. Each clock phase is held for a parameterised number of system clocks so that a slow device can follow it.

Once the last bit has gone out, the sequencer returns the select high. At the same time it raises a completion flag that stays set until the next reset. The sampling front end downstream uses this flag as its start permission. Inside each 4-bit channel field the codes 0 to 7 select inverting gains of 0, 1, 2, 5, 10, 20, 50 and 100. The tied-off variant sends code 1, a gain of -1, on both channels.

Top module: `gain_cfg_ctrl`

## Requirements
- R1: While rst_n is low, spi_cs_n_o is 1, spi_sck_o is 0, spi_mosi_o is 0 and cfg_done_o is 0, whatever the gain inputs are.
- R2: The transmitted word is {1'b0, code_B, 1'b0, code_A}, where code_A is gain_codes_i[2:0] and code_B is gain_codes_i[5:3]. Each 3-bit code 0..7 selects an inverting gain of 0, 1, 2, 5, 10, 20, 50 or 100. With GAIN_FROM_PINS=0 the word carries DEFAULT_CODE (default 1) in both fields, which gives 8'h11.
- R3: Exactly 8 rising serial-clock edges occur per configuration. The data value seen at the k-th rising edge (k = 1..8) is word bit 8-k, so the most significant bit goes first.
- R4: spi_mosi_o does not change while spi_sck_o is high.
- R5: Every high phase of spi_sck_o lasts exactly PHASE_CLKS system clocks. Every low phase between two pulses lasts PHASE_CLKS+1 clocks.
- R6: spi_cs_n_o falls PHASE_CLKS clocks before the first rising serial-clock edge. spi_sck_o is never high while spi_cs_n_o is high.
- R7: spi_cs_n_o rises PHASE_CLKS+1 clocks after the last falling serial-clock edge, and cfg_done_o rises in that same cycle.
- R8: Once set, cfg_done_o stays 1 until reset. After that the link stays idle (select high, clock low) and further changes to the gain inputs cause no traffic.
- R9: spi_cs_n_o falls 2 clocks after reset release. cfg_done_o rises 8*(2*PHASE_CLKS+1)+PHASE_CLKS+2 clocks after reset release, counting the first rising edge with rst_n high as clock 1. This is clock 44 with the default parameters.
- R10: The gain inputs are captured once, in the cycle before the select falls. Changing them during the transfer does not alter the transmitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts one configuration |
| gain_codes_i | input | NUM_CH*CODE_W (6) | Per-channel gain codes, channel A in the low bits |
| spi_sck_o | output | 1 | Serial clock to the amplifier |
| spi_mosi_o | output | 1 | Serial data to the amplifier |
| spi_cs_n_o | output | 1 | Active-low device select |
| cfg_done_o | output | 1 | Sticky flag: configuration finished, capture may start |

## Verification
All outputs are registered. The select falls on clock 2 after reset release. Rising serial-clock edges follow at clock 2+PHASE_CLKS+i*(2*PHASE_CLKS+1), and the select and the completion flag rise together on clock 44 by default. The bench works these cycle numbers out from the parameters. It samples the outputs on the falling system-clock edge after each rising edge, and it indexes every event by the number of rising edges since reset release, so each comparison refers to a known register update.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SCK_LO,
      ST_SCK_HI,
      ST_CHECK,
      ST_TAIL,
      ST_DONE
   } cfg_state_e;

   // Magnitude of the inverting gain chosen by a 3-bit code
   function automatic int unsigned gain_magnitude(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 1;
         3'd2:    return 2;
         3'd3:    return 5;
         3'd4:    return 10;
         3'd5:    return 20;
         3'd6:    return 50;
         default: return 100;
      endcase
   endfunction

endpackage

// File: rtl/gcfg_word_build.sv
module gcfg_word_build #(
   parameter int NUM_CH    = 2,
   parameter int CODE_W    = 3,
   parameter int FIELD_W   = 4,
   parameter bit FROM_PINS = 1'b1,
   parameter int DEF_CODE  = 1,
   localparam int WORD_W   = NUM_CH * FIELD_W,
   localparam int PAD_W    = FIELD_W - CODE_W
) (
   input  logic [NUM_CH*CODE_W-1:0] codes_i,
   output logic [WORD_W-1:0]        word_o
);

   initial begin
      assert (FIELD_W > CODE_W) else $error("field must be wider than code");
      assert (NUM_CH >= 1) else $error("need at least one channel");
      assert (DEF_CODE >= 0 && DEF_CODE < (1 << CODE_W)) else $error("default code out of range");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_field
      if (FROM_PINS) begin : g_pin
         assign word_o[ch*FIELD_W +: FIELD_W] =
            {{PAD_W{1'b0}}, codes_i[ch*CODE_W +: CODE_W]};
      end else begin : g_tie
         assign word_o[ch*FIELD_W +: FIELD_W] =
            {{PAD_W{1'b0}}, CODE_W'(DEF_CODE)};
      end
   end

endmodule

// File: rtl/gcfg_phase_timer.sv
module gcfg_phase_timer #(
   parameter int PHASE_CLKS = 2,
   localparam int CW = $clog2(PHASE_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);

   localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (PHASE_CLKS >= 1) else $error("phase length must be at least one clock");
   end

   assign expire_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run_i && !expire_o)
         cnt_q <= cnt_q + 1'b1;
      else
         cnt_q <= '0;
   end

   // R5: the phase counter never passes the programmed length
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R5: a counter left running always comes back to zero after expiry
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/gcfg_shifter.sv
module gcfg_shifter #(
   parameter int WORD_W = 8,
   localparam int BW = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rotate_i,
   output logic              msb_o,
   output logic              last_o
);

   logic [WORD_W-1:0] sreg_q;
   logic [BW-1:0]     bcnt_q;

   initial begin
      assert (WORD_W >= 2) else $error("word must hold at least two bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg_q <= '0;
         bcnt_q <= '0;
      end else if (load_i) begin
         sreg_q <= word_i;
         bcnt_q <= BW'(WORD_W);
      end else if (rotate_i) begin
         sreg_q <= {sreg_q[WORD_W-2:0], sreg_q[WORD_W-1]};
         bcnt_q <= bcnt_q - 1'b1;
      end
   end

   assign msb_o  = sreg_q[WORD_W-1];
   assign last_o = (bcnt_q == '0);

   // R3: no more bits are shifted than the word holds
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rotate_i |-> !last_o);

   // R3: a load always leaves a full bit count behind
   p_full_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !last_o);

endmodule

// File: rtl/gain_cfg_ctrl.sv
module gain_cfg_ctrl
   import gcfg_pkg::*;
#(
   parameter int NUM_CH         = 2,
   parameter int CODE_W         = 3,
   parameter int FIELD_W        = 4,
   parameter int PHASE_CLKS     = 2,
   parameter bit GAIN_FROM_PINS = 1'b1,
   parameter int DEFAULT_CODE   = 1,
   localparam int WORD_W        = NUM_CH * FIELD_W,
   localparam int IN_W          = NUM_CH * CODE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IN_W-1:0] gain_codes_i,
   output logic            spi_sck_o,
   output logic            spi_mosi_o,
   output logic            spi_cs_n_o,
   output logic            cfg_done_o
);

   cfg_state_e        state_q;
   logic              sck_q;
   logic              cs_n_q;
   logic              done_q;
   logic [WORD_W-1:0] word;
   logic              timer_run;
   logic              phase_exp;
   logic              load;
   logic              rotate;
   logic              msb;
   logic              last_bit;

   gcfg_word_build #(
      .NUM_CH    (NUM_CH),
      .CODE_W    (CODE_W),
      .FIELD_W   (FIELD_W),
      .FROM_PINS (GAIN_FROM_PINS),
      .DEF_CODE  (DEFAULT_CODE)
   ) u_word (
      .codes_i (gain_codes_i),
      .word_o  (word)
   );

   gcfg_phase_timer #(
      .PHASE_CLKS (PHASE_CLKS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (timer_run),
      .expire_o (phase_exp)
   );

   gcfg_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .word_i   (word),
      .rotate_i (rotate),
      .msb_o    (msb),
      .last_o   (last_bit)
   );

   assign timer_run = (state_q == ST_SCK_LO) || (state_q == ST_SCK_HI) ||
                      (state_q == ST_TAIL);
   assign load      = (state_q == ST_LOAD);
   assign rotate    = (state_q == ST_SCK_HI) && phase_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: state_q <= ST_LOAD;
            ST_LOAD: begin
               cs_n_q  <= 1'b0;
               state_q <= ST_SCK_LO;
            end
            ST_SCK_LO: if (phase_exp) begin
               sck_q   <= 1'b1;
               state_q <= ST_SCK_HI;
            end
            ST_SCK_HI: if (phase_exp) begin
               sck_q   <= 1'b0;
               state_q <= ST_CHECK;
            end
            ST_CHECK: state_q <= last_bit ? ST_TAIL : ST_SCK_LO;
            ST_TAIL: if (phase_exp) begin
               cs_n_q  <= 1'b1;
               done_q  <= 1'b1;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_DONE;
         endcase
      end
   end

   assign spi_sck_o  = sck_q;
   assign spi_cs_n_o = cs_n_q;
   assign spi_mosi_o = msb & ~cs_n_q;
   assign cfg_done_o = done_q;

   // R6: the serial clock only toggles inside a selected frame
   p_sck_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck_o |-> !spi_cs_n_o);

   // R4: data held steady across the whole high phase
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

   // R8: completion is sticky
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done_o |=> cfg_done_o);

   // R8: the link is idle once configuration has finished
   p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done_o |-> (spi_cs_n_o && !spi_sck_o));

   // R7: select release and completion coincide
   p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n_o) |-> cfg_done_o);

endmodule

// File: tb/gain_cfg_ctrl_test.sv
module gain_cfg_ctrl_test;

   localparam int PH      = 2;
   localparam int NV      = 6;
   localparam int PERIOD  = 2 * PH + 1;
   localparam int EXP_CSF = 2;
   localparam int EXP_R1  = EXP_CSF + PH;
   localparam int EXP_LF  = EXP_R1 + 7 * PERIOD + PH;
   localparam int EXP_DN  = 8 * PERIOD + PH + 2;
   localparam int RUN_LEN = 80;

   // codes {B, A}
   localparam logic [5:0] VEC [NV] = '{
      {3'd1, 3'd1}, {3'd0, 3'd0}, {3'd7, 3'd7},
      {3'd5, 3'd2}, {3'd3, 3'd6}, {3'd4, 3'd1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] gain_codes = '0;
   logic       sck, mosi, cs_n, done;
   logic       d_sck, d_mosi, d_cs_n, d_done;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   int cs_fall, cs_rise, first_rise, last_fall, done_cyc, rises;
   int hi_start, hi_err, gap_err, mosi_err, frame_err, post_err, d_rises;
   logic [7:0] bits, d_bits;

   always #4 clk = ~clk;

   gain_cfg_ctrl #(.PHASE_CLKS(PH)) uut (
      .clk(clk), .rst_n(rst_n), .gain_codes_i(gain_codes),
      .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_cs_n_o(cs_n), .cfg_done_o(done)
   );

   gain_cfg_ctrl #(.PHASE_CLKS(PH), .GAIN_FROM_PINS(1'b0)) uut_def (
      .clk(clk), .rst_n(rst_n), .gain_codes_i(gain_codes),
      .spi_sck_o(d_sck), .spi_mosi_o(d_mosi), .spi_cs_n_o(d_cs_n), .cfg_done_o(d_done)
   );

   function automatic logic [7:0] exp_word(input logic [5:0] c);
      return {1'b0, c[5:3], 1'b0, c[2:0]};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cfg(input logic [5:0] codes, input bit disturb);
      logic p_sck, p_mosi, p_cs, p_dsck;
      rst_n = 1'b0;
      gain_codes = codes;
      repeat (3) @(negedge clk);
      cs_fall = 0; cs_rise = 0; first_rise = 0; last_fall = 0; done_cyc = 0;
      rises = 0; hi_start = 0; hi_err = 0; gap_err = 0; mosi_err = 0;
      frame_err = 0; post_err = 0; d_rises = 0; bits = '0; d_bits = '0;
      p_sck = sck; p_mosi = mosi; p_cs = cs_n; p_dsck = d_sck;
      rst_n = 1'b1;
      for (int cyc = 1; cyc <= RUN_LEN; cyc++) begin
         @(negedge clk);
         if (cs_n == 1'b0 && p_cs == 1'b1) cs_fall = cyc;
         if (cs_n == 1'b1 && p_cs == 1'b0) cs_rise = cyc;
         if (sck && !p_sck) begin
            rises++;
            if (rises == 1) first_rise = cyc;
            else if (cyc - last_fall != PH + 1) gap_err++;
            if (rises <= 8) bits[8 - rises] = mosi;
            hi_start = cyc;
         end
         if (!sck && p_sck) begin
            last_fall = cyc;
            if (cyc - hi_start != PH) hi_err++;
         end
         if (sck && p_sck && mosi != p_mosi) mosi_err++;
         if (sck && cs_n) frame_err++;
         if (done && done_cyc == 0) done_cyc = cyc;
         if (done_cyc != 0 && cyc > done_cyc && (!done || sck || !cs_n)) post_err++;
         if (d_sck && !p_dsck) begin
            d_rises++;
            if (d_rises <= 8) d_bits[8 - d_rises] = d_mosi;
         end
         if (disturb && cyc == 6) gain_codes = ~codes;
         if (done_cyc != 0 && cyc == done_cyc + 4) gain_codes = ~gain_codes;
         p_sck = sck; p_mosi = mosi; p_cs = cs_n; p_dsck = d_sck;
      end
   endtask

   initial begin
      // R1: outputs while held in reset, with busy-looking gain inputs
      rst_n = 1'b0;
      gain_codes = 6'b111111;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R1 cs_n in reset", int'(cs_n), 1);
         check("R1 sck in reset", int'(sck), 0);
         check("R1 mosi in reset", int'(mosi), 0);
         check("R1 done in reset", int'(done), 0);
      end

      // Vector table walk: every vector is a full configuration from reset
      for (int v = 0; v < NV; v++) begin
         run_cfg(VEC[v], 1'b0);
         check("R2 transmitted word", int'(bits), int'(exp_word(VEC[v])));
         check("R3 rising edge count", rises, 8);
         check("R4 mosi changes while sck high", mosi_err, 0);
         check("R5 high phase length errors", hi_err, 0);
         check("R5 low gap length errors", gap_err, 0);
         check("R6 cs_n fall cycle", cs_fall, EXP_CSF);
         check("R6 first rising sck cycle", first_rise, EXP_R1);
         check("R6 sck high outside frame", frame_err, 0);
         check("R7 last falling sck cycle", last_fall, EXP_LF);
         check("R7 cs_n rise cycle", cs_rise, EXP_LF + PH + 1);
         check("R9 done cycle", done_cyc, EXP_DN);
         check("R8 activity after done", post_err, 0);
         check("R2 tied-off default word", int'(d_bits), 8'h11);
      end

      // R10: gain inputs changed during the transfer are not picked up
      run_cfg({3'd2, 3'd5}, 1'b1);
      check("R10 word after mid-transfer change", int'(bits), int'(exp_word({3'd2, 3'd5})));
      check("R10 done cycle unchanged", done_cyc, EXP_DN);
      check("R8 no traffic after done with input change", post_err, 0);

      // R1: a second reset returns the outputs to idle after a finished run
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 done cleared by reset", int'(done), 0);
      check("R1 cs_n high under reset", int'(cs_n), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule